// File: doc/BRIEF.md
# Latched Scaler Bank with FIFO Readout

This block keeps one event counter for each of its input signals and one more counter that advances on every clock cycle. Each input is passed through a short synchroniser and its rising edges are counted. A host write to the command port can freeze every counter into a bank of hold registers on the same clock edge, clear every live counter, or do both at once.

The held values serve two consumers. A host can read any held value at random by writing a scaler index into an address register and reading the data port. Each accepted freeze command also starts a burst into a shared event FIFO. The burst writes a header word that carries the number of words that follow, then writes every held value in index order. The burst pauses while the FIFO reports full. A new freeze command is not accepted until the burst has finished.

Top module: `scaler_bank`

## Requirements
- R1: A command write with bit 0 set, accepted while no burst is running, copies every live counter into its hold register on that same clock edge and starts a FIFO burst.
- R2: A command write with bit 1 set zeroes every live counter. The clock counter then advances by one on every edge, so a freeze taken k edges after the clear edge holds k-1.
- R3: Counter index i (0 to NUM_INPUTS-1) counts rising edges of input bit i after a two-flop synchroniser. Index NUM_INPUTS is the clock counter. Counters are 32 bits wide and wrap.
- R4: An address write stores bits [31:16] as the scaler select, and bits [15:0] have no effect. rd_data returns the held value of the selected index, or zero when the select exceeds NUM_INPUTS.
- R5: num_inputs constantly reports NUM_INPUTS.
- R6: A burst writes exactly NUM_INPUTS+2 words: first the header {16'hFE00, 16'(NUM_INPUTS+1)}, then held values 0 to NUM_INPUTS in order. The header is offered in the cycle after the freeze edge.
- R7: The same command write with both bits set freezes the values from before the clear. Afterwards the live counters start from zero.
- R8: fifo_wr stays low while fifo_full is high. The offered word is held through the stall, and the burst then resumes with no word lost or repeated.
- R9: A freeze command that arrives during a burst is ignored: the held values do not change, and no extra burst follows.
- R10: After reset the live counters and the held values are zero, and fifo_wr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | NUM_INPUTS | Asynchronous signals to count |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word: bit 0 freeze, bit 1 clear |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 32 | Address word; bits [31:16] select the scaler |
| rd_data | output | 32 | Held value of the selected scaler |
| num_inputs | output | 16 | Number of counted inputs |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |

## Verification
Each table entry gives each input its own pulse count and applies its own pattern of FIFO-full cycles. The counts therefore show whether the per-index ordering is right. The different stall patterns show whether a word is dropped or repeated around a pause, and a zero-pulse entry separates a correct clear from stale counts. Directed cases follow. A combined freeze and clear shows which edge's values are captured. A freeze sent during a fully stalled burst shows whether it is wrongly accepted. Reads with junk in the low address bits, and with out-of-range selects, check the address decoding.

// File: rtl/scaler_pkg.sv
// Shared types and constants for the scaler bank.
// Assumes FIFO words are 32 bits wide, with a 16-bit header tag and a 16-bit count.
package scaler_pkg;
    typedef enum logic [1:0] {
        BURST_IDLE = 2'd0,
        BURST_HDR  = 2'd1,
        BURST_DATA = 2'd2
    } burst_state_t;

    localparam logic [15:0] HDR_TAG = 16'hFE00;
endpackage

// File: rtl/scaler_sync_edge.sv
// Synchronises a vector of asynchronous inputs and flags one-cycle rising edges.
// Assumes each input pulse stays high and low for at least one clock period.
module scaler_sync_edge #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    // first synchroniser flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // further synchroniser flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    // delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/scaler_counter.sv
// One wrapping event counter with a synchronous clear that wins over increment.
module scaler_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [DATA_W-1:0] cnt
);
    // count events, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scaler_snapshot.sv
// Hold registers for all counters, with a random-access read port and a burst read port.
// Assumes capture is a one-cycle pulse; burst_idx is always in range.
module scaler_snapshot #(
    parameter int NUM_SCALERS = 8,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               capture,
    input  logic [NUM_SCALERS-1:0][DATA_W-1:0] live,
    input  logic [15:0]                        rd_sel,
    input  logic [IDX_W-1:0]                   burst_idx,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [DATA_W-1:0]                  burst_word
);
    logic [DATA_W-1:0] held [NUM_SCALERS];

    // copy every live counter on capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SCALERS; i++) held[i] <= '0;
        end else if (capture) begin
            for (int i = 0; i < NUM_SCALERS; i++) held[i] <= live[i];
        end
    end

    // host read: zero for an out-of-range select
    always_comb begin
        rd_data = '0;
        if (rd_sel < 16'(NUM_SCALERS)) rd_data = held[rd_sel[IDX_W-1:0]];
    end

    assign burst_word = held[burst_idx];
endmodule

// File: rtl/scaler_burst.sv
// Sends a header word and then every held value into the FIFO, pausing while it is full.
// Assumes the FIFO takes a word on any cycle where fifo_wr is high and fifo_full is low.
module scaler_burst
    import scaler_pkg::*;
#(
    parameter int NUM_SCALERS = 8,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              fifo_full,
    input  logic [DATA_W-1:0] word_in,
    output logic [IDX_W-1:0]  idx,
    output logic              accept,
    output logic              busy,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SCALERS - 1);
    localparam logic [15:0]      COUNT_FIELD = 16'(NUM_SCALERS);
    localparam logic [DATA_W-1:0] HEADER = DATA_W'({HDR_TAG, COUNT_FIELD});

    burst_state_t state;

    assign busy    = (state != BURST_IDLE);
    assign accept  = start_req && !busy;
    assign fifo_wr = busy && !fifo_full;

    // pick the offered word
    always_comb begin
        case (state)
            BURST_HDR:  fifo_wdata = HEADER;
            BURST_DATA: fifo_wdata = word_in;
            default:    fifo_wdata = '0;
        endcase
    end

    // advance through header and data words when the FIFO takes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BURST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                BURST_IDLE: if (start_req) begin
                    state <= BURST_HDR;
                    idx   <= '0;
                end
                BURST_HDR: if (!fifo_full) state <= BURST_DATA;
                BURST_DATA: if (!fifo_full) begin
                    if (idx == LAST_IDX) state <= BURST_IDLE;
                    else                 idx   <= idx + 1'b1;
                end
                default: state <= BURST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scaler_bank.sv
// Top of the scaler bank: synchronised edge counters, a clock counter,
// hold registers, the host select register and the FIFO burst engine.
// Assumes command and address strobes are one-cycle pulses in the clk domain.
module scaler_bank #(
    parameter int NUM_INPUTS = 59,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] sig_in,
    input  logic                  cmd_wr,
    input  logic [31:0]           cmd_wdata,
    input  logic                  addr_wr,
    input  logic [31:0]           addr_wdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic [15:0]           num_inputs,
    input  logic                  fifo_full,
    output logic                  fifo_wr,
    output logic [DATA_W-1:0]     fifo_wdata
);
    localparam int NUM_SCALERS = NUM_INPUTS + 1;
    localparam int IDX_W       = $clog2(NUM_SCALERS);

    logic [NUM_INPUTS-1:0]              rise;
    logic [NUM_SCALERS-1:0][DATA_W-1:0] live;
    logic [15:0]                        sel_q;
    logic [IDX_W-1:0]                   burst_idx;
    logic [DATA_W-1:0]                  burst_word;
    logic                               latch_req, clr_req, accept, burst_busy;

    assign latch_req  = cmd_wr && cmd_wdata[0];
    assign clr_req    = cmd_wr && cmd_wdata[1];
    assign num_inputs = 16'(NUM_INPUTS);

    scaler_sync_edge #(.WIDTH(NUM_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise)
    );

    generate
        for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_cnt
            scaler_counter #(.DATA_W(DATA_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr_req), .inc(rise[g]), .cnt(live[g])
            );
        end
    endgenerate

    scaler_counter #(.DATA_W(DATA_W)) u_clk_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .inc(1'b1), .cnt(live[NUM_INPUTS])
    );

    // host scaler select from the upper address half
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (addr_wr) sel_q <= addr_wdata[31:16];
    end

    scaler_snapshot #(.NUM_SCALERS(NUM_SCALERS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .capture(accept), .live(live), .rd_sel(sel_q),
        .burst_idx(burst_idx), .rd_data(rd_data), .burst_word(burst_word)
    );

    scaler_burst #(.NUM_SCALERS(NUM_SCALERS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .start_req(latch_req), .fifo_full(fifo_full),
        .word_in(burst_word), .idx(burst_idx), .accept(accept), .busy(burst_busy),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
    );
endmodule

// File: rtl/scaler_bank_checker.sv
// Protocol checks on the FIFO burst and the hold registers of scaler_bank.
module scaler_bank_checker #(
    parameter int NUM_SCALERS = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_wdata,
    input logic              addr_wr,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy
);
    logic [15:0] wcnt;

    // count words written in the current burst
    always_ff @(posedge clk) begin
        if (!rst_n)       wcnt <= '0;
        else if (fifo_wr) wcnt <= wcnt + 1'b1;
        else if (!busy)   wcnt <= '0;
    end

    p_hdr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && wcnt == 16'd0) |-> fifo_wdata == DATA_W'({16'hFE00, 16'(NUM_SCALERS)}));

    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wcnt == 16'(NUM_SCALERS + 1));

    p_no_wr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fifo_full) |=> fifo_wdata == $past(fifo_wdata));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !addr_wr) |=> $stable(rd_data));
endmodule

bind scaler_bank scaler_bank_checker #(.NUM_SCALERS(NUM_SCALERS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .addr_wr(addr_wr), .rd_data(rd_data), .busy(burst_busy)
);

// File: tb/scaler_bank_test.sv
module scaler_bank_test;
    localparam int N  = 6;
    localparam int NS = N + 1;

    // vector: [31:24] FIFO-full pattern, [4c+3:4c] pulses on input c
    localparam logic [31:0] VEC [4] = '{
        32'h00_654321, 32'h5A_0F0A05, 32'hEE_000000, 32'h33_F0F0F0
    };

    logic        clk = 0, rst_n = 0;
    logic [N-1:0] sig_in = '0;
    logic        cmd_wr = 0, addr_wr = 0, fifo_full = 0;
    logic [31:0] cmd_wdata = '0, addr_wdata = '0;
    logic [31:0] rd_data, fifo_wdata;
    logic [15:0] num_inputs;
    logic        fifo_wr;

    int checks = 0, errors = 0, tick = 0;
    int t_clr, t_lat, gotn;
    logic [31:0] got [16];
    bit done = 0;

    scaler_bank #(.NUM_INPUTS(N)) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .rd_data(rd_data),
        .num_inputs(num_inputs), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // command write; returns at the next negedge, stamp is tick before the edge
    task automatic command(input logic [1:0] bits, output int stamp);
        cmd_wr = 1; cmd_wdata = {30'd0, bits}; stamp = tick;
        @(negedge clk);
        cmd_wr = 0; cmd_wdata = '0;
    endtask

    task automatic select(input logic [15:0] sel, input logic [15:0] junk);
        addr_wr = 1; addr_wdata = {sel, junk};
        @(negedge clk);
        addr_wr = 0;
        #1;
    endtask

    task automatic pulses(input logic [23:0] cnts);
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < N; c++) sig_in[c] = (p < int'(cnts[4*c +: 4]));
            repeat (3) @(negedge clk);
            sig_in = '0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    // gather FIFO writes for 60 cycles under a repeating full pattern
    task automatic collect(input logic [7:0] pat);
        gotn = 0;
        for (int i = 0; i < 60; i++) begin
            fifo_full = pat[i % 8];
            #1;
            if (fifo_wr) begin
                if (gotn < 16) got[gotn] = fifo_wdata;
                gotn++;
            end
            @(negedge clk);
        end
        fifo_full = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state, R5 input count
        check("R10 fifo_wr after reset", 32'(fifo_wr), 32'd0);
        check("R10 held value after reset", rd_data, 32'd0);
        check("R5 num_inputs", 32'(num_inputs), 32'(N));
        @(negedge clk);

        // table walk: R1 R2 R3 R6 R8
        foreach (VEC[v]) begin
            command(2'b10, t_clr);
            pulses(VEC[v][23:0]);
            command(2'b01, t_lat);
            collect(VEC[v][31:24]);
            check("R6 word count", 32'(gotn), 32'(NS + 1));
            check("R6 header", got[0], {16'hFE00, 16'(NS)});
            for (int c = 0; c < N; c++)
                check("R3 R1 R8 channel word", got[1 + c], 32'(VEC[v][4*c +: 4]));
            check("R2 clock word", got[NS], 32'(t_lat - t_clr - 1));
        end

        // R4 random reads against the last table entry
        select(16'd1, 16'hBEEF);
        check("R4 sel 1", rd_data, 32'hF);
        select(16'd2, 16'h1234);
        check("R4 sel 2", rd_data, 32'h0);
        select(16'(N), 16'hFFFF);
        check("R4 sel clock", rd_data, 32'(t_lat - t_clr - 1));
        select(16'(NS), 16'h0);
        check("R4 sel out of range", rd_data, 32'd0);

        // R7 freeze and clear in one write
        command(2'b10, t_clr);
        pulses(24'h000003);
        command(2'b11, t_lat);
        collect(8'h00);
        check("R7 pre-clear channel 0", got[1], 32'd3);
        check("R7 pre-clear clock", got[NS], 32'(t_lat - t_clr - 1));
        t_clr = t_lat;
        command(2'b01, t_lat);
        collect(8'h00);
        check("R7 post-clear channel 0", got[1], 32'd0);
        check("R7 post-clear clock", got[NS], 32'(t_lat - t_clr - 1));

        // R9 freeze during a stalled burst is ignored; R8 resume
        command(2'b10, t_clr);
        pulses(24'h000002);
        fifo_full = 1;
        command(2'b01, t_lat);
        select(16'd0, 16'h0);
        check("R8 no write while full", 32'(fifo_wr), 32'd0);
        check("R9 held before", rd_data, 32'd2);
        pulses(24'h000003);
        command(2'b01, t_clr);
        #1;
        check("R9 held after ignored freeze", rd_data, 32'd2);
        collect(8'h00);
        check("R9 single burst count", 32'(gotn), 32'(NS + 1));
        check("R9 R8 channel 0 word", got[1], 32'd2);
        command(2'b01, t_lat);
        collect(8'h00);
        check("R3 counting continued", got[1], 32'd5);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule